// File: doc/BRIEF.md
# Serial Charge-Sharing DAC Switch Sequencer

This block is the digital controller for a serial charge-redistribution converter built from two equal capacitors and four analog switches. It takes one parallel word, then walks through its bits least significant first, one conversion cycle per bit. Each cycle is split into a charge phase and a share phase with idle ticks between them, so the two phase enables are never high together. In the charge phase the working capacitor is pulled to the reference or to ground according to the current bit. In the share phase it is connected across the holding capacitor. In the first cycle, and only there, the holding capacitor is also cleared during the charge phase.

The word enters through a valid/ready handshake. `in_ready` is high exactly while the block is idle. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. While a conversion runs, `in_ready` stays low and anything on `in_valid`/`in_data` is ignored; the source must hold its word until `in_ready` returns. After the last share phase, the block raises a sample strobe to capture the settled holding voltage. The strobe is delayed by a settling interval and then clipped to the share phase. A one-tick `done` follows, and the block returns to idle with every switch open.

All timing counts ticks of the fast system clock. One conversion cycle is 2·(PH_TICKS+DEAD_TICKS) ticks, which is 8 with the default values. It runs charge ticks, then dead ticks, then share ticks, then dead ticks.

Top module: `sdac_switch_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is lowered mid-conversion, all switch outputs, both phase enables, `sample`, `busy` and `done` are 0, and `in_ready` is 1.
- R2: A word is taken on an edge with `in_valid`=1 and `in_ready`=1, and `busy` is 1 from that edge on. `in_ready` is the inverse of `busy`. `in_valid` while busy changes no output of the running conversion and starts no second conversion.
- R3: Counting ticks from the accepting edge, tick t of cycle c=t/8 has phase position p=t%8. `ph1_en` is high for p in 0..2 and `ph2_en` for p in 4..6. The two enables are never high together.
- R4: During `ph1_en`, `sw_s1`=0, `sw_s2` equals the current bit and `sw_s3` its inverse. In cycle c the current bit is `in_data[c]`, so bit 0 (LSB) comes first.
- R5: `sw_s4` is high only during `ph1_en` of cycle 0.
- R6: During `ph2_en`, `sw_s1`=1 and `sw_s2`, `sw_s3` and `sw_s4` are 0.
- R7: On dead ticks and while idle, all four switches are 0.
- R8: `sample` is high on exactly two ticks per conversion, p=5 and p=6 of the last cycle (t=29,30), and only while `sw_s1` is high.
- R9: `done` is high for the single tick t=31. On the next tick `busy` and `done` are 0 and `in_ready` is 1.
- R10: An ideal two-capacitor model driven by the switches (share: v=(v+bit·Vref)/2; S4 clears v) holds code·Vref/16 when `sample` is high, for every 4-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | word offered |
| in_ready | output | 1 | block idle, word can be taken |
| in_data | input | NBITS | parallel data word |
| ph1_en | output | 1 | charge phase enable |
| ph2_en | output | 1 | share phase enable |
| sw_s1 | output | 1 | share switch (capacitors joined) |
| sw_s2 | output | 1 | working capacitor to reference |
| sw_s3 | output | 1 | working capacitor to ground |
| sw_s4 | output | 1 | holding capacitor clear |
| sample | output | 1 | capture strobe for the result |
| busy | output | 1 | conversion in progress |
| done | output | 1 | one-tick end of conversion |

## Verification
If the tick counter slips, the phase enables and switches are out of step with the arithmetic schedule on the very next tick. A wrong bit counter or wrong data index shows as a mismatched `sw_s2`/`sw_s3` in the first charge phase of the affected cycle, and as a wrong sampled voltage at tick 29. A faulty strobe delay or clip shows as a strobe on the wrong tick or outside S1. A stuck busy shows at tick 32, when `in_ready` and the idle switch state are checked. The sweep over all sixteen codes makes every bit value reach every cycle position.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ONE   = 3'd1,
    PH_GAP_A = 3'd2,
    PH_TWO   = 3'd3,
    PH_GAP_B = 3'd4
  } sdac_phase_e;

  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } sdac_sw_t;

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer
  import sdac_pkg::*;
#(
  parameter int PH_TICKS   = 3,
  parameter int DEAD_TICKS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        run,
  output sdac_phase_e phase,
  output logic        cycle_end,
  output logic        share_first
);
  localparam int CYC = 2 * (PH_TICKS + DEAD_TICKS);
  localparam int TW  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [TW-1:0] LAST    = TW'(CYC - 1);
  localparam logic [TW-1:0] ONE_END = TW'(PH_TICKS);
  localparam logic [TW-1:0] TWO_BEG = TW'(PH_TICKS + DEAD_TICKS);
  localparam logic [TW-1:0] TWO_END = TW'(2 * PH_TICKS + DEAD_TICKS);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (restart) begin
      tick_q <= '0;
    end else if (run) begin
      tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
    end
  end

  always_comb begin
    if (!run)                  phase = PH_IDLE;
    else if (tick_q < ONE_END) phase = PH_ONE;
    else if (tick_q < TWO_BEG) phase = PH_GAP_A;
    else if (tick_q < TWO_END) phase = PH_TWO;
    else                       phase = PH_GAP_B;
  end

  assign cycle_end   = run && (tick_q == LAST);
  assign share_first = run && (tick_q == TWO_BEG);
endmodule

// File: rtl/sdac_bit_select.sv
module sdac_bit_select #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] word,
  input  logic             step,
  output logic             cur_bit,
  output logic             first_cyc,
  output logic             last_cyc
);
  localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] TOP = CW'(NBITS - 1);

  logic [NBITS-1:0] word_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      word_q <= word;
      cnt_q  <= TOP;
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // down counter starts at the top, so the first cycle picks bit 0
  assign idx       = TOP - cnt_q;
  assign cur_bit   = word_q[idx];
  assign first_cyc = (cnt_q == TOP);
  assign last_cyc  = (cnt_q == '0);
endmodule

// File: rtl/sdac_switch_decode.sv
module sdac_switch_decode
  import sdac_pkg::*;
(
  input  sdac_phase_e phase,
  input  logic        cur_bit,
  input  logic        first_cyc,
  output logic        ph1,
  output logic        ph2,
  output sdac_sw_t    sw
);
  always_comb begin
    ph1   = (phase == PH_ONE);
    ph2   = (phase == PH_TWO);
    sw.s1 = ph2;
    sw.s2 = ph1 && cur_bit;
    sw.s3 = ph1 && !cur_bit;
    sw.s4 = ph1 && first_cyc;
  end
endmodule

// File: rtl/sdac_sample_gate.sv
module sdac_sample_gate #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_raw,
  input  logic share_on,
  output logic strobe
);
  logic req_dly;

  generate
    if (DLY == 0) begin : g_nodly
      assign req_dly = req_raw;
    end else begin : g_dly
      logic [DLY-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else if (DLY == 1) pipe_q <= req_raw;
        else pipe_q <= {pipe_q[DLY-2:0], req_raw};
      end
      assign req_dly = pipe_q[DLY-1];
    end
  endgenerate

  // clip: the delayed request may only show while the share switch is on
  assign strobe = req_dly && share_on;
endmodule

// File: rtl/sdac_switch_seq.sv
module sdac_switch_seq
  import sdac_pkg::*;
#(
  parameter int NBITS      = 4,
  parameter int PH_TICKS   = 3,
  parameter int DEAD_TICKS = 1,
  parameter int SAMPLE_DLY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NBITS-1:0] in_data,
  output logic             ph1_en,
  output logic             ph2_en,
  output logic             sw_s1,
  output logic             sw_s2,
  output logic             sw_s3,
  output logic             sw_s4,
  output logic             sample,
  output logic             busy,
  output logic             done
);
  logic        busy_q;
  logic        accept;
  sdac_phase_e phase;
  logic        cycle_end;
  logic        share_first;
  logic        cur_bit;
  logic        first_cyc;
  logic        last_cyc;
  sdac_sw_t    sw;

  assign accept = in_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done)   busy_q <= 1'b0;
  end

  sdac_phase_timer #(
    .PH_TICKS  (PH_TICKS),
    .DEAD_TICKS(DEAD_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (accept),
    .run        (busy_q),
    .phase      (phase),
    .cycle_end  (cycle_end),
    .share_first(share_first)
  );

  sdac_bit_select #(
    .NBITS(NBITS)
  ) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .word     (in_data),
    .step     (cycle_end),
    .cur_bit  (cur_bit),
    .first_cyc(first_cyc),
    .last_cyc (last_cyc)
  );

  sdac_switch_decode u_dec (
    .phase    (phase),
    .cur_bit  (cur_bit),
    .first_cyc(first_cyc),
    .ph1      (ph1_en),
    .ph2      (ph2_en),
    .sw       (sw)
  );

  sdac_sample_gate #(
    .DLY(SAMPLE_DLY)
  ) u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_raw (ph2_en && last_cyc),
    .share_on(sw.s1),
    .strobe  (sample)
  );

  assign sw_s1    = sw.s1;
  assign sw_s2    = sw.s2;
  assign sw_s3    = sw.s3;
  assign sw_s4    = sw.s4;
  assign busy     = busy_q;
  assign in_ready = !busy_q;
  assign done     = cycle_end && last_cyc;

  logic unused_ok;
  assign unused_ok = share_first;
endmodule

// File: rtl/sdac_switch_seq_chk.sv
module sdac_switch_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ph1_en,
  input logic ph2_en,
  input logic sw_s1,
  input logic sw_s2,
  input logic sw_s3,
  input logic sw_s4,
  input logic sample,
  input logic busy,
  input logic done
);
  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_en && ph2_en));
  // R4
  charge_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_en |-> (sw_s2 != sw_s3) && !sw_s1);
  // R5
  clear_in_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_s4 |-> ph1_en);
  // R6
  share_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_en |-> sw_s1 && !sw_s2 && !sw_s3 && !sw_s4);
  // R7
  idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sw_s1 && !sw_s2 && !sw_s3 && !sw_s4);
  // R8
  strobe_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> sw_s1 && busy);
  // R2
  take_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

bind sdac_switch_seq sdac_switch_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .ph1_en  (ph1_en),
  .ph2_en  (ph2_en),
  .sw_s1   (sw_s1),
  .sw_s2   (sw_s2),
  .sw_s3   (sw_s3),
  .sw_s4   (sw_s4),
  .sample  (sample),
  .busy    (busy),
  .done    (done)
);

// File: tb/sdac_switch_seq_bench.sv
module sdac_switch_seq_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [3:0] in_data;
  logic       ph1_en, ph2_en, sw_s1, sw_s2, sw_s3, sw_s4;
  logic       sample, busy, done;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  sdac_switch_seq u_sdac_switch_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .sw_s1(sw_s1), .sw_s2(sw_s2), .sw_s3(sw_s3), .sw_s4(sw_s4),
    .sample(sample), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " sw"}, int'({sw_s1, sw_s2, sw_s3, sw_s4}), 0);
    chk({tag, " ph"}, int'({ph1_en, ph2_en}), 0);
    chk({tag, " smp/busy/done"}, int'({sample, busy, done}), 0);
    chk({tag, " ready"}, int'(in_ready), 1);
  endtask

  task automatic run_word(input logic [3:0] code, input bit inject);
    real vout, v1, got;
    logic prev_s1;
    chk("R2 ready before word", int'(in_ready), 1);
    in_valid = 1'b1;
    in_data  = code;
    @(negedge clk);
    in_valid = 1'b0;
    vout = 0.0; v1 = 0.0; got = -1.0; prev_s1 = 1'b0;
    for (int t = 0; t < 32; t++) begin
      int c, p;
      logic b, e1, e2;
      c  = t / 8;
      p  = t % 8;
      b  = code[c];
      e1 = (p < 3);
      e2 = (p >= 4 && p < 7);
      chk("R2 busy", int'(busy), 1);
      chk("R2 ready low", int'(in_ready), 0);
      chk("R3 ph1_en", int'(ph1_en), int'(e1));
      chk("R3 ph2_en", int'(ph2_en), int'(e2));
      chk("R6 s1", int'(sw_s1), int'(e2));
      chk("R4 s2", int'(sw_s2), int'(e1 && b));
      chk("R4 s3", int'(sw_s3), int'(e1 && !b));
      chk("R5 s4", int'(sw_s4), int'(e1 && c == 0));
      if (!e1 && !e2) chk("R7 dead tick switches",
                          int'({sw_s1, sw_s2, sw_s3, sw_s4}), 0);
      chk("R8 sample", int'(sample), int'(c == 3 && (p == 5 || p == 6)));
      chk("R9 done", int'(done), int'(t == 31));
      if (sw_s4) vout = 0.0;
      if (sw_s2) v1 = 1.0;
      if (sw_s3) v1 = 0.0;
      if (sw_s1 && !prev_s1) vout = (vout + v1) / 2.0;
      if (sample) got = vout;
      prev_s1 = sw_s1;
      if (inject && t == 10) begin
        in_valid = 1'b1;
        in_data  = ~code;
      end else begin
        in_valid = 1'b0;
        in_data  = code;
      end
      @(negedge clk);
    end
    chk_idle("R9 after done");
    total++;
    if (got != real'(code) / 16.0) begin
      bad++;
      $display("FAIL R10 code=%0d actual=%f expected=%f", code, got,
               real'(code) / 16.0);
    end
    repeat (3) begin
      @(negedge clk);
      chk("R2 no second conversion", int'(busy), 0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R7 idle");
    for (int k = 0; k < 16; k++) run_word(4'(k), (k % 2) == 1);
    run_word(4'b1011, 1'b0);
    // R1: reset in the middle of a conversion
    in_valid = 1'b1;
    in_data  = 4'd9;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after mid reset");
    run_word(4'd6, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule